// File: doc/BRIEF.md
# Two-Stage Automatic Level Controller

This block keeps the level of a stereo audio capture path between two programmable limits. For each channel it watches the signed samples taken after the digital attenuator and steers two gain settings: a PGA gain code for the analog amplifier ahead of the converter, and a digital attenuation code in half-decibel units. When peaks get too loud it pulls gain down, and when the signal stays quiet it gives gain back.

The two settings are moved in a fixed priority. On attack, PGA gain is lowered first, and attenuation is added only once the PGA sits at its lowest code. On release, attenuation is removed first, and the PGA is raised only once attenuation is zero. PGA gain is never raised past a programmed ceiling. Attack and release steps each have their own pacing window. Steps can be held back until the signal crosses zero, with a timeout that forces the step. Soft ramping selects between single half-decibel attenuation steps and coarse ones. While a channel's controller is disabled, software loads both codes directly. While it is enabled, those loads are ignored.

Top module: `alc_stereo`

## Requirements
- R1: After reset both channels report PGA code 0 and attenuation code 0. A disabled channel never steps, whatever samples arrive.
- R2: An attack step lowers the PGA code by one while it is above 0. When the PGA code is 0, the attack step adds attenuation instead. A single step never changes both codes.
- R3: A release step removes attenuation while it is above 0. When attenuation is 0, the release step raises the PGA code by one.
- R4: A 3-bit threshold code k stands for the level 2^(SW-1) >> k, which is 6 dB per code below full scale. A sample is loud when its absolute value is strictly above the high-threshold level. It is quiet when its absolute value is strictly below the low-threshold level. Samples between the two levels cause no step.
- R5: If the low-threshold code is smaller than the high-threshold code, the low threshold is treated as equal to the high one. The low threshold then names a higher level, and this substitution stops it from doing so.
- R6: Attack windows and release windows each last (rate code + 1) sample strobes and start when the channel is enabled. A window ends in an attack step if any sample in it was loud. It ends in a release step if every sample in it was quiet. Attack wins when both fall on the same strobe. Codes change only on the clock edge that takes a sample strobe.
- R7: Release never raises the PGA code above the 5-bit limit. An enabled channel whose PGA code is above the limit is set to the limit on the next clock.
- R8: A manual load strobe copies the manual PGA and attenuation codes into a disabled channel. On an enabled channel the strobe has no effect.
- R9: With soft ramping on, an attenuation step is 1 code (0.5 dB). With soft ramping off it is HARD_STEP codes (default 4). Attenuation is clamped to the range 0 to 255. A PGA step is always one code.
- R10: With zero-cross gating on, a requested step waits until a sample's sign bit differs from the previous sample's sign bit. If no crossing comes, the step is forced on the ZC_TO-th strobe after the request (default 864, which is 18 ms at 48 kHz).
- R11: The channels are independent. Enables, samples, manual loads and codes of one channel do not affect the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| smp_vld | input | 1 | Sample strobe, one cycle per sample period |
| smp_data | input | NCH x SW | Post-attenuator signed samples, one per channel |
| alc_en | input | NCH | Controller enable per channel |
| zc_en | input | 1 | Zero-cross gating of steps |
| ramp_en | input | 1 | Soft ramping (fine attenuation steps) |
| thr_hi | input | 3 | High threshold code |
| thr_lo | input | 3 | Low threshold code |
| atk_rate | input | 6 | Attack window code |
| rel_rate | input | 6 | Release window code |
| pga_lim | input | 5 | Highest PGA code allowed |
| man_wr | input | NCH | Manual load strobe per channel |
| man_pga | input | 5 | Manual PGA code |
| man_att | input | 8 | Manual attenuation code |
| pga_code | output | NCH x 5 | Current PGA code per channel |
| att_code | output | NCH x 8 | Current attenuation code per channel |

## Verification
The main path is driven with runs of loud samples starting from a raised PGA code. This tells the PGA-first attack order apart from any mixed order. Runs of quiet samples starting from nonzero attenuation show the attenuation-first release order and the stop at the PGA ceiling. Samples sitting exactly on a threshold level, and their negative counterparts, separate the strict comparisons and the magnitude handling from off-by-one variants. A window holding a single loud sample among mid-level ones separates any-peak detection from all-peak detection. Same-sign runs followed by one sign flip, and a long same-sign run, show the crossing rule and the exact timeout strobe.

// File: rtl/alc_pkg.sv
package alc_pkg;

  localparam int THR_W  = 3;
  localparam int RATE_W = 6;

  // Level of threshold code k: full scale shifted down by k (6 dB per code).
  function automatic logic [31:0] level_of(int unsigned w, logic [THR_W-1:0] code);
    return (32'd1 << (w - 1)) >> code;
  endfunction

  // The low threshold may not name a higher level than the high one.
  function automatic logic [THR_W-1:0] fold_lo(logic [THR_W-1:0] hi, logic [THR_W-1:0] lo);
    return (lo < hi) ? hi : lo;
  endfunction

  function automatic logic [31:0] sat_up(logic [31:0] v, logic [31:0] d, logic [31:0] lim);
    return (v + d > lim) ? lim : v + d;
  endfunction

  function automatic logic [31:0] sat_dn(logic [31:0] v, logic [31:0] d);
    return (v > d) ? v - d : 32'd0;
  endfunction

endpackage

// File: rtl/alc_level_det.sv
module alc_level_det
  import alc_pkg::*;
#(
  parameter int SW = 16
) (
  input  logic [SW-1:0]    smp,
  input  logic [THR_W-1:0] thr_hi,
  input  logic [THR_W-1:0] thr_lo,
  output logic             loud,
  output logic             quiet,
  output logic             neg
);

  logic [SW-1:0] mag;
  logic [SW-1:0] lvl_hi;
  logic [SW-1:0] lvl_lo;

  assign neg    = smp[SW-1];
  assign mag    = neg ? (~smp + 1'b1) : smp;
  assign lvl_hi = SW'(level_of(SW, thr_hi));
  assign lvl_lo = SW'(level_of(SW, fold_lo(thr_hi, thr_lo)));
  assign loud   = mag > lvl_hi;
  assign quiet  = mag < lvl_lo;

endmodule

// File: rtl/alc_pacer.sv
module alc_pacer
  import alc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              stb,
  input  logic              loud,
  input  logic              quiet,
  input  logic [RATE_W-1:0] atk_rate,
  input  logic [RATE_W-1:0] rel_rate,
  output logic              atk_req,
  output logic              rel_req
);

  logic [RATE_W-1:0] atk_cnt, rel_cnt;
  logic              loud_seen, quiet_all;
  logic              atk_end, rel_end, loud_w, quiet_w;

  assign atk_end = atk_cnt >= atk_rate;
  assign rel_end = rel_cnt >= rel_rate;
  assign loud_w  = loud_seen | loud;
  assign quiet_w = quiet_all & quiet;
  assign atk_req = stb & atk_end & loud_w;
  assign rel_req = stb & rel_end & quiet_w & ~atk_req;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      atk_cnt   <= '0;
      rel_cnt   <= '0;
      loud_seen <= 1'b0;
      quiet_all <= 1'b1;
    end else if (clr) begin
      atk_cnt   <= '0;
      rel_cnt   <= '0;
      loud_seen <= 1'b0;
      quiet_all <= 1'b1;
    end else if (stb) begin
      atk_cnt   <= atk_end ? '0 : atk_cnt + 1'b1;
      loud_seen <= atk_end ? 1'b0 : loud_w;
      rel_cnt   <= rel_end ? '0 : rel_cnt + 1'b1;
      quiet_all <= rel_end ? 1'b1 : quiet_w;
    end
  end

endmodule

// File: rtl/alc_zc_gate.sv
module alc_zc_gate #(
  parameter int ZC_TO = 864
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic stb,
  input  logic zc_en,
  input  logic neg,
  input  logic atk_req,
  input  logic rel_req,
  output logic fire,
  output logic fire_atk
);

  localparam int TOW = $clog2(ZC_TO + 1);
  localparam logic [TOW-1:0] TO_LAST = TOW'(ZC_TO - 1);

  logic           pend_v, pend_atk, prev_neg;
  logic [TOW-1:0] to_cnt;
  logic           req, zc_hit, to_hit;

  assign req      = atk_req | rel_req;
  assign zc_hit   = neg != prev_neg;
  assign to_hit   = pend_v & (to_cnt >= TO_LAST);
  assign fire     = stb & (req | pend_v) & (~zc_en | zc_hit | to_hit);
  assign fire_atk = req ? atk_req : pend_atk;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_neg <= 1'b0;
    end else if (stb) begin
      prev_neg <= neg;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_v   <= 1'b0;
      pend_atk <= 1'b0;
      to_cnt   <= '0;
    end else if (clr) begin
      pend_v   <= 1'b0;
      to_cnt   <= '0;
    end else if (stb) begin
      if (fire) begin
        pend_v <= 1'b0;
        to_cnt <= '0;
      end else if (req | pend_v) begin
        pend_v   <= 1'b1;
        pend_atk <= fire_atk;
        to_cnt   <= pend_v ? to_cnt + 1'b1 : '0;
      end
    end
  end

endmodule

// File: rtl/alc_gain_step.sv
module alc_gain_step
  import alc_pkg::*;
#(
  parameter int PW        = 5,
  parameter int AW        = 8,
  parameter int HARD_STEP = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          fire,
  input  logic          fire_atk,
  input  logic          ramp_en,
  input  logic [PW-1:0] pga_lim,
  input  logic          man_wr,
  input  logic [PW-1:0] man_pga,
  input  logic [AW-1:0] man_att,
  output logic [PW-1:0] pga,
  output logic [AW-1:0] att
);

  localparam logic [31:0] ATT_TOP = 32'((64'd1 << AW) - 1);

  logic [31:0] st;
  assign st = ramp_en ? 32'd1 : 32'(HARD_STEP);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pga <= '0;
      att <= '0;
    end else if (!en) begin
      if (man_wr) begin
        pga <= man_pga;
        att <= man_att;
      end
    end else if (pga > pga_lim) begin
      pga <= pga_lim;
    end else if (fire) begin
      if (fire_atk) begin
        if (pga != '0) pga <= pga - 1'b1;
        else           att <= AW'(sat_up(32'(att), st, ATT_TOP));
      end else begin
        if (att != '0)         att <= AW'(sat_dn(32'(att), st));
        else if (pga < pga_lim) pga <= pga + 1'b1;
      end
    end
  end

endmodule

// File: rtl/alc_channel.sv
module alc_channel
  import alc_pkg::*;
#(
  parameter int SW        = 16,
  parameter int PW        = 5,
  parameter int AW        = 8,
  parameter int HARD_STEP = 4,
  parameter int ZC_TO     = 864
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              stb,
  input  logic [SW-1:0]     smp,
  input  logic              en,
  input  logic              zc_en,
  input  logic              ramp_en,
  input  logic [THR_W-1:0]  thr_hi,
  input  logic [THR_W-1:0]  thr_lo,
  input  logic [RATE_W-1:0] atk_rate,
  input  logic [RATE_W-1:0] rel_rate,
  input  logic [PW-1:0]     pga_lim,
  input  logic              man_wr,
  input  logic [PW-1:0]     man_pga,
  input  logic [AW-1:0]     man_att,
  output logic [PW-1:0]     pga,
  output logic [AW-1:0]     att,
  output logic              fire
);

  logic loud, quiet, neg, atk_req, rel_req, fire_atk;

  alc_level_det #(.SW(SW)) u_det (
    .smp(smp), .thr_hi(thr_hi), .thr_lo(thr_lo),
    .loud(loud), .quiet(quiet), .neg(neg)
  );

  alc_pacer u_pace (
    .clk(clk), .rst_n(rst_n), .clr(~en), .stb(stb),
    .loud(loud), .quiet(quiet), .atk_rate(atk_rate), .rel_rate(rel_rate),
    .atk_req(atk_req), .rel_req(rel_req)
  );

  alc_zc_gate #(.ZC_TO(ZC_TO)) u_zc (
    .clk(clk), .rst_n(rst_n), .clr(~en), .stb(stb), .zc_en(zc_en), .neg(neg),
    .atk_req(atk_req), .rel_req(rel_req), .fire(fire), .fire_atk(fire_atk)
  );

  alc_gain_step #(.PW(PW), .AW(AW), .HARD_STEP(HARD_STEP)) u_gain (
    .clk(clk), .rst_n(rst_n), .en(en), .fire(fire), .fire_atk(fire_atk),
    .ramp_en(ramp_en), .pga_lim(pga_lim), .man_wr(man_wr),
    .man_pga(man_pga), .man_att(man_att), .pga(pga), .att(att)
  );

endmodule

// File: rtl/alc_stereo.sv
module alc_stereo
  import alc_pkg::*;
#(
  parameter int NCH       = 2,
  parameter int SW        = 16,
  parameter int PW        = 5,
  parameter int AW        = 8,
  parameter int HARD_STEP = 4,
  parameter int ZC_TO     = 864
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    smp_vld,
  input  logic [NCH-1:0][SW-1:0]  smp_data,
  input  logic [NCH-1:0]          alc_en,
  input  logic                    zc_en,
  input  logic                    ramp_en,
  input  logic [THR_W-1:0]        thr_hi,
  input  logic [THR_W-1:0]        thr_lo,
  input  logic [RATE_W-1:0]       atk_rate,
  input  logic [RATE_W-1:0]       rel_rate,
  input  logic [PW-1:0]           pga_lim,
  input  logic [NCH-1:0]          man_wr,
  input  logic [PW-1:0]           man_pga,
  input  logic [AW-1:0]           man_att,
  output logic [NCH-1:0][PW-1:0]  pga_code,
  output logic [NCH-1:0][AW-1:0]  att_code
);

  // Step events of each channel, brought out for the checker.
  logic [NCH-1:0] ch_fire;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    alc_channel #(
      .SW(SW), .PW(PW), .AW(AW), .HARD_STEP(HARD_STEP), .ZC_TO(ZC_TO)
    ) u_ch (
      .clk(clk), .rst_n(rst_n), .stb(smp_vld), .smp(smp_data[c]),
      .en(alc_en[c]), .zc_en(zc_en), .ramp_en(ramp_en),
      .thr_hi(thr_hi), .thr_lo(thr_lo), .atk_rate(atk_rate), .rel_rate(rel_rate),
      .pga_lim(pga_lim), .man_wr(man_wr[c]), .man_pga(man_pga), .man_att(man_att),
      .pga(pga_code[c]), .att(att_code[c]), .fire(ch_fire[c])
    );
  end

endmodule

// File: rtl/alc_stereo_chk.sv
module alc_stereo_chk #(
  parameter int NCH       = 2,
  parameter int PW        = 5,
  parameter int AW        = 8,
  parameter int HARD_STEP = 4
) (
  input logic                   clk,
  input logic                   rst_n,
  input logic                   smp_vld,
  input logic [NCH-1:0]         alc_en,
  input logic [PW-1:0]          pga_lim,
  input logic [NCH-1:0][PW-1:0] pga_code,
  input logic [NCH-1:0][AW-1:0] att_code,
  input logic [NCH-1:0]         ch_fire
);

  for (genvar c = 0; c < NCH; c++) begin : g_chk
    a_r2_att_only_at_pga_floor: assert property (@(posedge clk) disable iff (!rst_n)
      (alc_en[c] && $past(alc_en[c]) && att_code[c] > $past(att_code[c]))
        |-> $past(pga_code[c]) == '0);

    a_r2_one_stage_per_step: assert property (@(posedge clk) disable iff (!rst_n)
      (alc_en[c] && $past(alc_en[c]))
        |-> !(!$stable(pga_code[c]) && !$stable(att_code[c])));

    a_r3_pga_only_at_att_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (alc_en[c] && $past(alc_en[c]) && pga_code[c] > $past(pga_code[c]))
        |-> $past(att_code[c]) == '0);

    a_r6_step_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
      ch_fire[c] |-> smp_vld);

    a_r8_hold_without_step: assert property (@(posedge clk) disable iff (!rst_n)
      (alc_en[c] && $past(alc_en[c]) && !$past(ch_fire[c])
        && $past(pga_code[c]) <= $past(pga_lim))
        |-> ($stable(pga_code[c]) && $stable(att_code[c])));

    a_r7_pga_under_limit: assert property (@(posedge clk) disable iff (!rst_n)
      (alc_en[c] && $past(alc_en[c]))
        |-> pga_code[c] <= $past(pga_lim) || pga_code[c] < $past(pga_code[c]));

    a_r9_att_step_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (alc_en[c] && $past(alc_en[c]))
        |-> (32'(att_code[c]) <= 32'($past(att_code[c])) + 32'(HARD_STEP)
             && 32'(att_code[c]) + 32'(HARD_STEP) >= 32'($past(att_code[c]))));
  end

endmodule

bind alc_stereo alc_stereo_chk #(
  .NCH(NCH), .PW(PW), .AW(AW), .HARD_STEP(HARD_STEP)
) u_chk (
  .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .alc_en(alc_en),
  .pga_lim(pga_lim), .pga_code(pga_code), .att_code(att_code), .ch_fire(ch_fire)
);

// File: tb/alc_stereo_tb.sv
module alc_stereo_tb;

  localparam int NCH = 2;
  localparam int SW  = 16;
  localparam int TO  = 864;

  logic                   clk = 1'b0;
  logic                   rst_n = 1'b0;
  logic                   smp_vld = 1'b0;
  logic [NCH-1:0][SW-1:0] smp_data = '0;
  logic [NCH-1:0]         alc_en = '0;
  logic                   zc_en = 1'b0;
  logic                   ramp_en = 1'b1;
  logic [2:0]             thr_hi = 3'd1;
  logic [2:0]             thr_lo = 3'd3;
  logic [5:0]             atk_rate = '0;
  logic [5:0]             rel_rate = '0;
  logic [4:0]             pga_lim = 5'd10;
  logic [NCH-1:0]         man_wr = '0;
  logic [4:0]             man_pga = '0;
  logic [7:0]             man_att = '0;
  logic [NCH-1:0][4:0]    pga_code;
  logic [NCH-1:0][7:0]    att_code;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // Sample values against thr_hi=1 (16384) and thr_lo=3 (4096).
  localparam int LOUD = 20000;
  localparam int MID  = 8000;
  localparam int QUIET = 1000;

  always #2.5 clk = ~clk;

  alc_stereo u_dut (
    .clk(clk), .rst_n(rst_n), .smp_vld(smp_vld), .smp_data(smp_data),
    .alc_en(alc_en), .zc_en(zc_en), .ramp_en(ramp_en), .thr_hi(thr_hi),
    .thr_lo(thr_lo), .atk_rate(atk_rate), .rel_rate(rel_rate), .pga_lim(pga_lim),
    .man_wr(man_wr), .man_pga(man_pga), .man_att(man_att),
    .pga_code(pga_code), .att_code(att_code)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic chk_ch(input string tag, input int c, input int p, input int a);
    chk({tag, " pga"}, int'(pga_code[c]), p);
    chk({tag, " att"}, int'(att_code[c]), a);
  endtask

  task automatic stb(input int s0, input int s1);
    @(negedge clk);
    smp_data[0] = 16'(s0);
    smp_data[1] = 16'(s1);
    smp_vld = 1'b1;
    @(negedge clk);
    smp_vld = 1'b0;
  endtask

  // Disable ch0, load codes, then enable again (windows restart).
  task automatic set0(input int p, input int a);
    @(negedge clk);
    alc_en[0] = 1'b0;
    man_wr[0] = 1'b1;
    man_pga = 5'(p);
    man_att = 8'(a);
    @(negedge clk);
    man_wr[0] = 1'b0;
    alc_en[0] = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_reset;
    chk_ch("R1 reset ch0", 0, 0, 0);
    chk_ch("R1 reset ch1", 1, 0, 0);
    stb(LOUD, -LOUD);
    stb(QUIET, QUIET);
    chk_ch("R1 disabled no step", 0, 0, 0);
  endtask

  task automatic t_manual;
    @(negedge clk);
    man_wr = 2'b11;
    man_pga = 5'd7;
    man_att = 8'd9;
    @(negedge clk);
    man_wr = '0;
    chk_ch("R8 load while disabled", 1, 7, 9);
    set0(3, 0);
    chk_ch("R8 load ch0", 0, 3, 0);
    man_wr[0] = 1'b1;
    man_pga = 5'd20;
    man_att = 8'd77;
    @(negedge clk);
    man_wr[0] = 1'b0;
    @(negedge clk);
    chk_ch("R8 load ignored when enabled", 0, 3, 0);
  endtask

  task automatic t_attack;
    int exp_p[5] = '{2, 1, 0, 0, 0};
    int exp_a[5] = '{0, 0, 0, 1, 2};
    for (int i = 0; i < 5; i++) begin
      stb(LOUD, LOUD);
      chk_ch($sformatf("R2 attack step %0d", i), 0, exp_p[i], exp_a[i]);
    end
    chk_ch("R11 disabled ch1 untouched", 1, 7, 9);
  endtask

  task automatic t_rate;
    atk_rate = 6'd2;
    rel_rate = 6'd1;
    set0(0, 2);
    stb(LOUD, 0);
    stb(LOUD, 0);
    chk_ch("R6 atk window not ended", 0, 0, 2);
    stb(LOUD, 0);
    chk_ch("R6 atk step after 3", 0, 0, 3);
    stb(MID, 0);
    stb(-LOUD, 0);
    stb(MID, 0);
    chk_ch("R6 one peak in window", 0, 0, 4);
    set0(0, 4);
    stb(QUIET, 0);
    chk_ch("R6 rel window not ended", 0, 0, 4);
    stb(QUIET, 0);
    chk_ch("R6 rel step after 2", 0, 0, 3);
    stb(QUIET, 0);
    stb(MID, 0);
    chk_ch("R6 rel needs all quiet", 0, 0, 3);
    atk_rate = 6'd0;
    rel_rate = 6'd0;
  endtask

  task automatic t_release;
    int exp_p[7] = '{0, 0, 1, 2, 3, 4, 4};
    int exp_a[7] = '{1, 0, 0, 0, 0, 0, 0};
    pga_lim = 5'd4;
    set0(0, 2);
    for (int i = 0; i < 7; i++) begin
      stb(QUIET, 0);
      chk_ch($sformatf("R3 R7 release step %0d", i), 0, exp_p[i], exp_a[i]);
    end
    set0(10, 0);
    chk_ch("R7 clamp to limit", 0, 4, 0);
    pga_lim = 5'd10;
  endtask

  task automatic t_levels;
    set0(2, 0);
    stb(MID, 0);
    stb(16384, 0);
    stb(-16384, 0);
    chk_ch("R4 at or below high level", 0, 2, 0);
    stb(-16385, 0);
    chk_ch("R4 negative loud", 0, 1, 0);
    set0(0, 3);
    stb(4096, 0);
    stb(-4096, 0);
    chk_ch("R4 at low level not quiet", 0, 0, 3);
    stb(-4095, 0);
    chk_ch("R4 just below low level", 0, 0, 2);
  endtask

  task automatic t_fold;
    thr_hi = 3'd3;
    thr_lo = 3'd1;
    set0(0, 5);
    for (int i = 0; i < 4; i++) stb(4096, 0);
    chk_ch("R5 folded low threshold", 0, 0, 5);
    stb(4095, 0);
    chk_ch("R5 quiet below folded", 0, 0, 4);
    thr_hi = 3'd1;
    thr_lo = 3'd3;
  endtask

  task automatic t_ramp;
    ramp_en = 1'b0;
    set0(0, 250);
    stb(LOUD, 0);
    chk_ch("R9 coarse attack", 0, 0, 254);
    stb(LOUD, 0);
    chk_ch("R9 clamp at 255", 0, 0, 255);
    stb(QUIET, 0);
    chk_ch("R9 coarse release", 0, 0, 251);
    set0(2, 0);
    stb(LOUD, 0);
    chk_ch("R9 pga step stays one", 0, 1, 0);
    ramp_en = 1'b1;
  endtask

  task automatic t_zc;
    zc_en = 1'b1;
    alc_en[0] = 1'b0;
    stb(QUIET, 0);
    set0(0, 0);
    for (int i = 0; i < 3; i++) stb(LOUD, 0);
    chk_ch("R10 waits for crossing", 0, 0, 0);
    stb(-LOUD, 0);
    chk_ch("R10 step at crossing", 0, 0, 1);
    for (int i = 0; i < TO; i++) stb(-LOUD, 0);
    chk_ch("R10 before timeout", 0, 0, 1);
    stb(-LOUD, 0);
    chk_ch("R10 forced by timeout", 0, 0, 2);
    chk_ch("R11 ch1 independent", 1, 7, 9);
    zc_en = 1'b0;
  endtask

  task automatic finish_run;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual hung expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_manual();
    t_attack();
    t_rate();
    t_release();
    t_levels();
    t_fold();
    t_ramp();
    t_zc();
    done = 1;
    finish_run();
  end

endmodule